// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for every beat of one SDRAM read or write burst. A command sequencer pulses a start strobe together with the first column, a burst-length code and an ordering select. From the following cycle the block presents one column address per clock with a valid flag, until the burst completes, is cut short by a stop request, or is replaced by a fresh start.

Fixed bursts of 1, 2, 4 or 8 beats stay inside their aligned block of columns. In sequential order the low bits count up and wrap. In interleaved order the low bits are the start column's low bits XOR the beat number. A full-page burst walks all 512 columns of the row, wraps from the top column to column 0, and only ends on a stop request. A last-beat flag marks the closing address of every fixed-length burst, so the sequencer can schedule its next command.

Top module: `burst_col_gen`

## Requirements
- R1: While reset is held, and after it is released with no start strobe, `colValid` and `lastBeat` are 0.
- R2: A start strobe sampled on a clock edge makes `colValid` 1 and `colOut` equal to the sampled `startCol` after that edge. The length code and ordering select are captured at the same edge and held for the whole burst.
- R3: Length code `lenCode` 3'b000 gives 1 beat, 3'b001 gives 2, 3'b010 gives 4 and 3'b011 gives 8. Every other code (3'b100 to 3'b111) selects a full-page burst.
- R4: With `interleaveSel`=0 and a fixed length BL, beat n has low log2(BL) bits equal to (start low bits + n) mod BL. The upper column bits equal those of the start column.
- R5: With `interleaveSel`=1 and a fixed length BL, beat n has low log2(BL) bits equal to start low bits XOR n. The upper column bits equal those of the start column.
- R6: In a full-page burst each beat is the previous column plus 1 modulo 512, so column 511 is followed by column 0. The burst continues until a stop request. `interleaveSel` has no effect in this mode.
- R7: `lastBeat` is 1 exactly on the final beat of a fixed-length burst and is never 1 in a full-page burst.
- R8: A stop request sampled without a start strobe drives `colValid` to 0 after that edge, and it stays 0 until the next start. A stop request while idle has no effect.
- R9: A start strobe during a burst restarts immediately with the new column, length and order. When a start strobe and a stop request arrive in the same cycle, the start wins.
- R10: After the final beat of a fixed-length burst, `colValid` drops to 0 on the next cycle unless a new start strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| startPulse | input | 1 | Begin a new burst at `startCol` |
| startCol | input | 9 | First column of the burst |
| lenCode | input | 3 | Burst length code (see R3) |
| interleaveSel | input | 1 | 1 selects interleaved order, 0 sequential |
| stopReq | input | 1 | Burst stop or precharge: end the burst |
| colOut | output | 9 | Column address of the current beat |
| colValid | output | 1 | `colOut` holds a live beat |
| lastBeat | output | 1 | Current beat closes a fixed-length burst |

## Verification
A corrupted beat counter or length mask shows up in `colOut` on the very next beat. It appears as a column outside the aligned block, a wrong ordering step, or a missing wrap at column 511. A wrong active state shows at the ports within one cycle of the event that should have changed it. It appears as a burst that keeps running past its final beat or past a stop request, a missing restart, or a `lastBeat` that comes early, comes late, or shows up in full-page mode. The directed scenarios compare every beat of each burst against an independently computed address, so either fault is reported on the cycle it first appears.

// File: rtl/bcol_pkg.sv
package bcol_pkg;

  // Strobes sent from the control half to the datapath half.
  typedef struct packed {
    logic load;   // capture a new start column and mode
    logic step;   // advance to the next beat
  } ctrlStrobeT;

endpackage

// File: rtl/bcol_datapath.sv
module bcol_datapath
  import bcol_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int LEN_W = 3,
  parameter int MAX_FIXED_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobeT       ctrl,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleaveSel,
  output logic [COL_W-1:0] colOut,
  output logic             finalBeat
);

  localparam int FIXED_CODES = MAX_FIXED_LOG2 + 1;
  localparam logic [COL_W-1:0] ALL_ONES = '1;

  logic [COL_W-1:0] baseCol;
  logic [COL_W-1:0] beatIdx;
  logic [COL_W-1:0] lenMask;
  logic             ilReg;
  logic             fullReg;

  logic [COL_W-1:0] nextMask;
  logic             nextFull;
  logic [COL_W-1:0] seqCol;
  logic [COL_W-1:0] ilCol;
  logic [COL_W-1:0] sumCol;

  // Decode the length code into a mask of the wrapping low bits.
  always_comb begin
    nextFull = (int'(lenCode) >= FIXED_CODES);
    nextMask = '0;
    if (nextFull) begin
      nextMask = ALL_ONES;
    end else begin
      for (int i = 0; i < COL_W; i++) begin
        if (i < int'(lenCode)) nextMask[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseCol <= '0;
      beatIdx <= '0;
      lenMask <= '0;
      ilReg   <= 1'b0;
      fullReg <= 1'b0;
    end else if (ctrl.load) begin
      baseCol <= startCol;
      beatIdx <= '0;
      lenMask <= nextMask;
      ilReg   <= interleaveSel & ~nextFull;
      fullReg <= nextFull;
    end else if (ctrl.step) begin
      beatIdx <= beatIdx + COL_W'(1);
    end
  end

  // Column forming: sequential keeps upper bits and wraps low bits,
  // interleaved XORs the beat number into the low bits.
  always_comb begin
    sumCol = baseCol + beatIdx;
    seqCol = (baseCol & ~lenMask) | (sumCol & lenMask);
    ilCol  = baseCol ^ (beatIdx & lenMask);
    colOut = ilReg ? ilCol : seqCol;
  end

  assign finalBeat = ~fullReg & (beatIdx == lenMask);

  // R2: a load presents the captured start column on the next cycle
  assert_load_col_R2: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> colOut == $past(startCol));

  // R4: each step moves the beat counter forward by exactly one
  assert_step_count_R4: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.step && !ctrl.load) |=> beatIdx == $past(beatIdx) + COL_W'(1));

  // R6: full page wraps from the top column to column zero
  assert_page_wrap_R6: assert property (@(posedge clk) disable iff (!rstN)
    (fullReg && ctrl.step && !ctrl.load && colOut == ALL_ONES) |=> colOut == '0);

  // R7: a fixed burst never steps beyond its final beat
  assert_no_overrun_R7: assert property (@(posedge clk) disable iff (!rstN)
    (finalBeat && !ctrl.load) |-> !ctrl.step);

endmodule

// File: rtl/bcol_control.sv
module bcol_control
  import bcol_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       startPulse,
  input  logic       stopReq,
  input  logic       finalBeat,
  output ctrlStrobeT ctrl,
  output logic       active
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
    end else if (startPulse) begin
      active <= 1'b1;
    end else if (stopReq) begin
      active <= 1'b0;
    end else if (active && finalBeat) begin
      active <= 1'b0;
    end
  end

  always_comb begin
    ctrl.load = startPulse;
    ctrl.step = active & ~startPulse & ~stopReq & ~finalBeat;
  end

  // R9: a start strobe always yields a live beat next cycle
  assert_start_live_R9: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> active);

  // R8: a stop without start silences the output next cycle
  assert_stop_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stopReq && !startPulse) |=> !active);

  // R10: the final fixed beat is followed by idle unless restarted
  assert_end_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (active && finalBeat && !startPulse) |=> !active);

  // R8: idle stays idle without a start
  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !startPulse) |=> !active);

endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
  import bcol_pkg::*;
#(
  parameter int COL_W = 9,
  parameter int LEN_W = 3,
  parameter int MAX_FIXED_LOG2 = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [COL_W-1:0] startCol,
  input  logic [LEN_W-1:0] lenCode,
  input  logic             interleaveSel,
  input  logic             stopReq,
  output logic [COL_W-1:0] colOut,
  output logic             colValid,
  output logic             lastBeat
);

  ctrlStrobeT ctrl;
  logic       finalBeat;
  logic       active;

  bcol_control u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startPulse(startPulse),
    .stopReq   (stopReq),
    .finalBeat (finalBeat),
    .ctrl      (ctrl),
    .active    (active)
  );

  bcol_datapath #(
    .COL_W         (COL_W),
    .LEN_W         (LEN_W),
    .MAX_FIXED_LOG2(MAX_FIXED_LOG2)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .startCol     (startCol),
    .lenCode      (lenCode),
    .interleaveSel(interleaveSel),
    .colOut       (colOut),
    .finalBeat    (finalBeat)
  );

  assign colValid = active;
  assign lastBeat = active & finalBeat;

  // R1: outputs are quiet in reset
  always_comb begin
    if (!rstN) begin
      assert_reset_quiet_R1: assert (!colValid && !lastBeat);
    end
  end

endmodule

// File: tb/burst_col_gen_tb.sv
`timescale 1ns/1ps
module burst_col_gen_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startPulse = 1'b0;
  logic [8:0] startCol = '0;
  logic [2:0] lenCode = '0;
  logic       interleaveSel = 1'b0;
  logic       stopReq = 1'b0;
  logic [8:0] colOut;
  logic       colValid;
  logic       lastBeat;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  burst_col_gen u_dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startCol(startCol),
    .lenCode(lenCode), .interleaveSel(interleaveSel), .stopReq(stopReq),
    .colOut(colOut), .colValid(colValid), .lastBeat(lastBeat)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int blOf(input int code);
    if (code < 4) return 1 << code;
    return 512;
  endfunction

  function automatic int expCol(input int s, input int bl, input bit il, input int n);
    int base;
    if (bl == 512) return (s + n) % 512;
    base = s - (s % bl);
    if (il) return base + ((s % bl) ^ n);
    return base + (((s % bl) + n) % bl);
  endfunction

  task automatic launch(input int s, input int code, input bit il, input bit stp);
    startPulse = 1'b1; startCol = 9'(s); lenCode = 3'(code);
    interleaveSel = il; stopReq = stp;
    tick();
    startPulse = 1'b0; stopReq = 1'b0;
    interleaveSel = ~il; lenCode = 3'(code ^ 1); startCol = ~startCol;
  endtask

  // R2 R3 R4 R5 R7 R10: complete fixed burst, every beat checked
  task automatic runFixed(input int s, input int code, input bit il, input string req);
    int bl = blOf(code);
    launch(s, code, il, 1'b0);
    for (int n = 0; n < bl; n++) begin
      chk({req, " valid"}, int'(colValid), 1);
      chk({req, " col"}, int'(colOut), expCol(s, bl, il, n));
      chk({"R7 last"}, int'(lastBeat), (n == bl - 1) ? 1 : 0);
      if (n < bl - 1) tick();
    end
    tick();
    chk("R10 idle after burst", int'(colValid), 0);
    chk("R10 last low", int'(lastBeat), 0);
  endtask

  // R6: full page walk across the wrap, then stop (R8)
  task automatic runPage(input int s, input int code, input bit il, input int beats);
    launch(s, code, il, 1'b0);
    for (int n = 0; n < beats; n++) begin
      chk("R6 page col", int'(colOut), (s + n) % 512);
      chk("R7 no last in page", int'(lastBeat), 0);
      chk("R6 page valid", int'(colValid), 1);
      if (n < beats - 1) tick();
    end
    stopReq = 1'b1;
    tick();
    stopReq = 1'b0;
    chk("R8 stop ends page", int'(colValid), 0);
    tick();
    chk("R8 stays idle", int'(colValid), 0);
  endtask

  task automatic stopMid();
    launch(9'h040, 3, 1'b0, 1'b0);
    tick();
    chk("R8 pre-stop col", int'(colOut), 9'h041);
    stopReq = 1'b1;
    tick();
    stopReq = 1'b0;
    chk("R8 stop mid burst", int'(colValid), 0);
    chk("R8 no last after stop", int'(lastBeat), 0);
    for (int k = 0; k < 3; k++) begin
      tick();
      chk("R8 remains idle", int'(colValid), 0);
    end
  endtask

  task automatic restartMid();
    launch(9'h010, 3, 1'b0, 1'b0);
    tick();
    chk("R9 old burst beat1", int'(colOut), 9'h011);
    launch(9'h123, 2, 1'b1, 1'b0);
    for (int n = 0; n < 4; n++) begin
      chk("R9 restarted col", int'(colOut), expCol(9'h123, 4, 1'b1, n));
      chk("R9 restarted last", int'(lastBeat), (n == 3) ? 1 : 0);
      if (n < 3) tick();
    end
    tick();
    chk("R9 restarted ends", int'(colValid), 0);
  endtask

  task automatic startWithStop();
    launch(9'h0AB, 1, 1'b0, 1'b1);
    chk("R9 start beats stop valid", int'(colValid), 1);
    chk("R9 start beats stop col", int'(colOut), 9'h0AB);
    tick();
    chk("R9 second beat", int'(colOut), 9'h0AA);
    chk("R9 second beat last", int'(lastBeat), 1);
    tick();
    chk("R9 ended", int'(colValid), 0);
  endtask

  task automatic stopIdle();
    stopReq = 1'b1;
    tick();
    stopReq = 1'b0;
    chk("R8 stop idle no effect", int'(colValid), 0);
    chk("R8 stop idle last", int'(lastBeat), 0);
    runFixed(9'h077, 1, 1'b0, "R8 burst after idle stop");
  endtask

  initial begin
    #1;
    chk("R1 reset valid", int'(colValid), 0);
    chk("R1 reset last", int'(lastBeat), 0);
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    chk("R1 post reset valid", int'(colValid), 0);
    chk("R1 post reset last", int'(lastBeat), 0);

    runFixed(9'h155, 0, 1'b0, "R3 len1");
    runFixed(9'h033, 1, 1'b0, "R4 seq len2");
    runFixed(9'h1F6, 2, 1'b0, "R4 seq len4");
    runFixed(9'h0AD, 3, 1'b0, "R4 seq len8");
    runFixed(9'h0D5, 3, 1'b1, "R5 il len8");
    runFixed(9'h1F6, 2, 1'b1, "R5 il len4");
    runFixed(9'h033, 1, 1'b1, "R5 il len2");
    runPage(9'h1FB, 7, 1'b0, 9);
    runPage(9'h1FE, 5, 1'b1, 5);
    runPage(9'h000, 4, 1'b0, 3);
    stopMid();
    restartMid();
    startWithStop();
    stopIdle();

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule